// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access at a time. Each request comes with an access-need mask (read, write, execute), a privilege index and a physical-mode flag. Three cases are settled at once, with no table read: a physical-mode pass-through, a badly sign-extended address, and the kernel direct-mapped window (the superpage). Every other address is resolved by walking a three-level table in memory. The walk uses a single-outstanding read port, where a request is held with its address until the data comes back valid.

A walk ends with a one-cycle `done` pulse. At that point the block presents the physical address, a permission mask and a fault flag with a code. These outputs stay unchanged until the next walk finishes. The block is meant to sit behind a translation cache that starts it on a miss.

The controller has three states, `S_IDLE`, `S_FETCH` and `S_REPORT`, and uses these transitions:
- `S_IDLE` to `S_REPORT`: a start arrives that the pre-screen resolves.
- `S_IDLE` to `S_FETCH`: a start arrives that needs a walk.
- `S_FETCH` to `S_FETCH`: a valid upper-level entry was accepted, so the next level is read.
- `S_FETCH` to `S_REPORT`: the leaf returns, or an upper-level entry is rejected.
- `S_REPORT` to `S_IDLE`: always, after one cycle.

Top module: `pt_walker`

## Requirements
- R1: When `phys_mode` is 1, the result is `paddr` equal to `vaddr`, with `perm`=3'b111 and no fault, and no memory read is made. Permission bits are bit0 read, bit1 write and bit2 exec. The same encoding is used for `need`.
- R2: If `phys_mode` is 0 and `vaddr[63:43]` are not all equal, the result is a fault with code 0 (access violation) and no read is made.
- R3: A sign-valid address with bit63=1 and `vaddr[42:41]`=2'b10 is a superpage and is resolved with no read. For `priv`=0 it maps to `paddr[39:0]`=`vaddr[39:0]`, `paddr[43]`=`vaddr[40]`, with all other bits 0 and `perm`=3'b111. For any other `priv` it faults with code 0. A negative address outside this window is walked.
- R4: The walk reads at `base + index*8`. The index is taken from `vaddr[42:33]` at level 1, `vaddr[32:23]` at level 2 and `vaddr[22:13]` at level 3. The level-1 base is `ptbase`. Each next base is `entry[63:32] << 13`. On success, `paddr` = (`leaf[63:32] << 13`) | `vaddr[12:0]`.
- R5: An entry with bit0 (valid) clear at any level ends the walk with fault code 4, and no further level is read.
- R6: A valid level-1 or level-2 entry with bit8 (kernel read) clear ends the walk with fault code 0.
- R7: At the leaf, read and exec permission come from bit (8+`priv`) and write permission comes from bit (12+`priv`). If `need` is nonzero and shares no bit with this mask, the result is fault code 0.
- R8: The leaf mask then loses read if bit1 is set, write if bit2 is set and exec if bit3 is set. If `need` is nonzero and shares no bit with the reduced mask, the fault code is 3 if `need` has exec, else 2 if it has write, else 1. If `need` is 0 and the leaf is valid, the walk succeeds.
- R9: `mem_req` stays high with `mem_addr` unchanged until `mem_valid` is seen. Only one read is outstanding at a time, and the result does not depend on read latency.
- R10: After reset, `done`, `mem_req`, `fault`, `fault_code`, `paddr` and `perm` are 0. `done` is high for exactly one cycle per walk. A start while busy is ignored. Results hold until the next walk completes. A faulted result has `paddr`=0 and `perm`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (accepted only when idle) |
| vaddr | input | 64 | Virtual address |
| need | input | 3 | Access needed: bit0 read, bit1 write, bit2 exec |
| priv | input | 2 | Privilege index, 0 is kernel |
| phys_mode | input | 1 | Physical-mode bypass |
| ptbase | input | 64 | Level-1 table base address |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 64 | Table read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Table entry read |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Translation failed |
| fault_code | output | 3 | 0 access, 1 on-read, 2 on-write, 3 on-exec, 4 not-valid |
| paddr | output | 64 | Physical address |
| perm | output | 3 | Granted permissions |

## Verification
A table of walks runs the same virtual address through varied leaf entries. This isolates each leaf rule: privilege-selected enables, every fault-on bit, the priority among them with a multi-bit need, and a zero need. Other entries break the chain at level 1 and at level 2, either on the valid bit or the kernel-read bit, and the count of reads shows where each walk stopped. Physical mode, a bad sign, superpage kernel and user accesses, and a negative non-window address show which cases avoid memory and which are walked. The walks are repeated with a slow responder, along with a start issued mid-walk and a check that results hold, to exercise the handshake and the controller.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FETCH  = 2'd1,
        S_REPORT = 2'd2
    } walk_state_e;

    // Fault encodings seen on the fault_code port
    localparam logic [2:0] FC_ACCESS    = 3'd0;
    localparam logic [2:0] FC_ON_READ   = 3'd1;
    localparam logic [2:0] FC_ON_WRITE  = 3'd2;
    localparam logic [2:0] FC_ON_EXEC   = 3'd3;
    localparam logic [2:0] FC_NOT_VALID = 3'd4;

    // Permission mask bit positions
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;
    localparam logic [2:0] PERM_ALL = 3'b111;

    // Table entry fields
    localparam int PTE_W          = 64;
    localparam int PTE_VALID_BIT  = 0;
    localparam int PTE_FOR_BIT    = 1;
    localparam int PTE_FOW_BIT    = 2;
    localparam int PTE_FOE_BIT    = 3;
    localparam int PTE_KREAD_BIT  = 8;
    localparam int PTE_KWRITE_BIT = 12;
    localparam int PTE_FRAME_LSB  = 32;

endpackage

// File: rtl/pt_prescreen.sv
module pt_prescreen
    import pt_walker_pkg::*;
#(
    parameter int VA_W        = 64,
    parameter int VA_IMPL     = 43,
    parameter int PRIV_W      = 2,
    parameter int SP_LOW_BITS = 40,
    parameter int SP_MOVED_TO = 43
) (
    input  logic [VA_W-1:0]   va,
    input  logic              phys_mode,
    input  logic [PRIV_W-1:0] priv,
    output logic              resolved,
    output logic              fault,
    output logic [2:0]        code,
    output logic [VA_W-1:0]   paddr,
    output logic [2:0]        perm
);
    localparam int HI_N = VA_W - VA_IMPL;

    logic [HI_N-1:0] hi_bits;
    logic            sign_ok;
    logic            in_window;
    logic            is_kernel;
    logic [VA_W-1:0] window_pa;

    assign hi_bits   = va[VA_W-1:VA_IMPL];
    assign sign_ok   = (&hi_bits) | (~|hi_bits);
    assign in_window = va[VA_W-1] && (va[VA_IMPL-1 -: 2] == 2'b10);
    assign is_kernel = (priv == '0);

    always_comb begin
        window_pa                  = '0;
        window_pa[SP_LOW_BITS-1:0] = va[SP_LOW_BITS-1:0];
        window_pa[SP_MOVED_TO]     = va[SP_LOW_BITS];
    end

    always_comb begin
        resolved = 1'b1;
        fault    = 1'b0;
        code     = FC_ACCESS;
        paddr    = '0;
        perm     = '0;
        if (phys_mode) begin
            paddr = va;
            perm  = PERM_ALL;
        end else if (!sign_ok) begin
            fault = 1'b1;
        end else if (in_window && !is_kernel) begin
            fault = 1'b1;
        end else if (in_window) begin
            paddr = window_pa;
            perm  = PERM_ALL;
        end else begin
            resolved = 1'b0;
        end
    end

endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int VA_W        = 64,
    parameter int PG_BITS     = 13,
    parameter int IDX_W       = 10,
    parameter int LEVELS      = 3,
    parameter int ENTRY_SHIFT = 3,
    parameter int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [VA_W-1:0]  va,
    input  logic [VA_W-1:0]  base,
    input  logic [LVL_W-1:0] level,
    output logic [VA_W-1:0]  addr
);
    localparam int TOP_USED = PG_BITS + IDX_W * LEVELS;

    logic [IDX_W-1:0] idx_lvl [LEVELS];
    logic [IDX_W-1:0] sel;
    logic             unused_va;

    // Level 0 takes the highest field, the last level the one above the offset
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_lvl[g] = va[PG_BITS + IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) sel = idx_lvl[i];
        end
    end

    assign addr      = base + (VA_W'(sel) << ENTRY_SHIFT);
    assign unused_va = ^{va[PG_BITS-1:0], va[VA_W-1:TOP_USED]};

endmodule

// File: rtl/pt_leaf_check.sv
module pt_leaf_check
    import pt_walker_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int PG_BITS = 13,
    parameter int PRIV_W  = 2
) (
    input  logic [PTE_W-1:0]   pte,
    input  logic [PG_BITS-1:0] va_off,
    input  logic [2:0]         need,
    input  logic [PRIV_W-1:0]  priv,
    output logic               fault,
    output logic [2:0]         code,
    output logic [VA_W-1:0]    paddr,
    output logic [2:0]         perm
);
    localparam int NPRIV   = 1 << PRIV_W;
    localparam int FRAME_W = PTE_W - PTE_FRAME_LSB;

    logic [NPRIV-1:0] rd_field;
    logic [NPRIV-1:0] wr_field;
    logic             rd_ok;
    logic             wr_ok;
    logic [2:0]       granted;
    logic [2:0]       fo_mask;
    logic [2:0]       reduced;
    logic [VA_W-1:0]  frame_pa;
    logic             unused_pte;

    assign rd_field = pte[PTE_KREAD_BIT +: NPRIV];
    assign wr_field = pte[PTE_KWRITE_BIT +: NPRIV];
    assign rd_ok    = rd_field[priv];
    assign wr_ok    = wr_field[priv];

    always_comb begin
        granted          = '0;
        granted[PERM_RD] = rd_ok;
        granted[PERM_EX] = rd_ok;
        granted[PERM_WR] = wr_ok;
        fo_mask          = '0;
        fo_mask[PERM_RD] = pte[PTE_FOR_BIT];
        fo_mask[PERM_WR] = pte[PTE_FOW_BIT];
        fo_mask[PERM_EX] = pte[PTE_FOE_BIT];
    end

    assign reduced  = granted & ~fo_mask;
    assign frame_pa = (VA_W'(pte[PTE_W-1:PTE_FRAME_LSB]) << PG_BITS)
                    | VA_W'(va_off);

    always_comb begin
        fault = 1'b1;
        code  = FC_ACCESS;
        paddr = '0;
        perm  = '0;
        if (!pte[PTE_VALID_BIT]) begin
            code = FC_NOT_VALID;
        end else if ((need != '0) && ((granted & need) == '0)) begin
            code = FC_ACCESS;
        end else if ((need != '0) && ((reduced & need) == '0)) begin
            if (need[PERM_EX])      code = FC_ON_EXEC;
            else if (need[PERM_WR]) code = FC_ON_WRITE;
            else                    code = FC_ON_READ;
        end else begin
            fault = 1'b0;
            paddr = frame_pa;
            perm  = reduced;
        end
    end

    assign unused_pte = ^{pte[PTE_KREAD_BIT-1:PTE_FOE_BIT+1],
                          pte[PTE_FRAME_LSB-1:PTE_KWRITE_BIT+NPRIV]};
    localparam int FRAME_CHECK = FRAME_W;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 43,
    parameter int PG_BITS = 13,
    parameter int IDX_W   = 10,
    parameter int LEVELS  = 3,
    parameter int PRIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [2:0]        need,
    input  logic [PRIV_W-1:0] priv,
    input  logic              phys_mode,
    input  logic [VA_W-1:0]   ptbase,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_valid,
    input  logic [PTE_W-1:0]  mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [2:0]        fault_code,
    output logic [VA_W-1:0]   paddr,
    output logic [2:0]        perm
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e state_q, state_d;

    logic [LVL_W-1:0]  level_q;
    logic [VA_W-1:0]   base_q;
    logic [VA_W-1:0]   va_q;
    logic [2:0]        need_q;
    logic [PRIV_W-1:0] priv_q;

    logic              res_fault;
    logic [2:0]        res_code;
    logic [VA_W-1:0]   res_paddr;
    logic [2:0]        res_perm;

    logic              pre_resolved;
    logic              pre_fault;
    logic [2:0]        pre_code;
    logic [VA_W-1:0]   pre_paddr;
    logic [2:0]        pre_perm;

    logic              leaf_fault;
    logic [2:0]        leaf_code;
    logic [VA_W-1:0]   leaf_paddr;
    logic [2:0]        leaf_perm;

    logic              at_leaf;
    logic              upper_invalid;
    logic              upper_noread;
    logic [VA_W-1:0]   next_base;

    pt_prescreen #(
        .VA_W    (VA_W),
        .VA_IMPL (VA_IMPL),
        .PRIV_W  (PRIV_W)
    ) u_prescreen (
        .va        (vaddr),
        .phys_mode (phys_mode),
        .priv      (priv),
        .resolved  (pre_resolved),
        .fault     (pre_fault),
        .code      (pre_code),
        .paddr     (pre_paddr),
        .perm      (pre_perm)
    );

    pt_entry_addr #(
        .VA_W    (VA_W),
        .PG_BITS (PG_BITS),
        .IDX_W   (IDX_W),
        .LEVELS  (LEVELS),
        .LVL_W   (LVL_W)
    ) u_entry_addr (
        .va    (va_q),
        .base  (base_q),
        .level (level_q),
        .addr  (mem_addr)
    );

    pt_leaf_check #(
        .VA_W    (VA_W),
        .PG_BITS (PG_BITS),
        .PRIV_W  (PRIV_W)
    ) u_leaf (
        .pte    (mem_rdata),
        .va_off (va_q[PG_BITS-1:0]),
        .need   (need_q),
        .priv   (priv_q),
        .fault  (leaf_fault),
        .code   (leaf_code),
        .paddr  (leaf_paddr),
        .perm   (leaf_perm)
    );

    assign at_leaf       = (level_q == LAST_LVL);
    assign upper_invalid = !mem_rdata[PTE_VALID_BIT];
    assign upper_noread  = !mem_rdata[PTE_KREAD_BIT];
    assign next_base     = VA_W'(mem_rdata[PTE_W-1:PTE_FRAME_LSB]) << PG_BITS;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = pre_resolved ? S_REPORT : S_FETCH;
            end
            S_FETCH: begin
                if (mem_valid && (at_leaf || upper_invalid || upper_noread))
                    state_d = S_REPORT;
            end
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= '0;
            base_q    <= '0;
            va_q      <= '0;
            need_q    <= '0;
            priv_q    <= '0;
            res_fault <= 1'b0;
            res_code  <= FC_ACCESS;
            res_paddr <= '0;
            res_perm  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        va_q    <= vaddr;
                        need_q  <= need;
                        priv_q  <= priv;
                        base_q  <= ptbase;
                        level_q <= '0;
                        if (pre_resolved) begin
                            res_fault <= pre_fault;
                            res_code  <= pre_code;
                            res_paddr <= pre_paddr;
                            res_perm  <= pre_perm;
                        end
                    end
                end
                S_FETCH: begin
                    if (mem_valid) begin
                        if (at_leaf) begin
                            res_fault <= leaf_fault;
                            res_code  <= leaf_code;
                            res_paddr <= leaf_paddr;
                            res_perm  <= leaf_perm;
                        end else if (upper_invalid) begin
                            res_fault <= 1'b1;
                            res_code  <= FC_NOT_VALID;
                            res_paddr <= '0;
                            res_perm  <= '0;
                        end else if (upper_noread) begin
                            res_fault <= 1'b1;
                            res_code  <= FC_ACCESS;
                            res_paddr <= '0;
                            res_perm  <= '0;
                        end else begin
                            base_q  <= next_base;
                            level_q <= level_q + LVL_W'(1);
                        end
                    end
                end
                S_REPORT: ;
                default: ;
            endcase
        end
    end

    assign mem_req    = (state_q == S_FETCH);
    assign done       = (state_q == S_REPORT);
    assign fault      = res_fault;
    assign fault_code = res_code;
    assign paddr      = res_paddr;
    assign perm       = res_perm;

    // R9: a pending read keeps its address until data returns
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: no read is outstanding while reporting
    a_r10_report_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R10: a faulted result carries no address or permission
    a_r10_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (paddr == '0 && perm == '0));

    // R5: only defined fault codes are reported
    a_r5_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault_code <= FC_NOT_VALID));

    // R1: physical mode resolves next cycle with the input address
    a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && phys_mode) |=>
        (done && !fault && perm == PERM_ALL && paddr == $past(vaddr)));

    // R8: success always covers what was needed
    a_r8_need_met: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> ((need_q == '0) || ((perm & need_q) != '0)));

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] PTB = 64'h0000_0000_0010_0000;
    localparam logic [63:0] VA  = 64'h0000_0006_0280_E123;
    localparam logic [63:0] PA  = 64'h0000_0001_579B_C123;
    localparam logic [63:0] L1G = 64'h0000_0100_0000_0101;
    localparam logic [63:0] L2G = 64'h0000_0200_0000_0101;
    localparam logic [63:0] LF  = 64'h000A_BCDE_0000_0000;

    typedef struct packed {
        logic [63:0] va;
        logic [2:0]  need;
        logic [1:0]  priv;
        logic        phys;
        logic [63:0] l1;
        logic [63:0] l2;
        logic [63:0] l3;
        logic        efault;
        logic [2:0]  ecode;
        logic [63:0] epa;
        logic [2:0]  eperm;
        logic [3:0]  ereads;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // R7 kernel read, all enables
        '{VA, 3'b001, 2'd0, 1'b0, L1G, L2G, LF | 64'h1101, 1'b0, 3'd0, PA, 3'b111, 4'd3, 4'd7},
        // R7 user write without write enable
        '{VA, 3'b010, 2'd1, 1'b0, L1G, L2G, LF | 64'h0301, 1'b1, 3'd0, 64'd0, 3'b000, 4'd3, 4'd7},
        // R7 user write with user enables
        '{VA, 3'b010, 2'd1, 1'b0, L1G, L2G, LF | 64'h2201, 1'b0, 3'd0, PA, 3'b111, 4'd3, 4'd7},
        // R8 fault on read
        '{VA, 3'b001, 2'd0, 1'b0, L1G, L2G, LF | 64'h0103, 1'b1, 3'd1, 64'd0, 3'b000, 4'd3, 4'd8},
        // R8 fault on exec
        '{VA, 3'b100, 2'd0, 1'b0, L1G, L2G, LF | 64'h0109, 1'b1, 3'd3, 64'd0, 3'b000, 4'd3, 4'd8},
        // R8 fault on write
        '{VA, 3'b010, 2'd0, 1'b0, L1G, L2G, LF | 64'h1105, 1'b1, 3'd2, 64'd0, 3'b000, 4'd3, 4'd8},
        // R5 leaf not valid
        '{VA, 3'b001, 2'd0, 1'b0, L1G, L2G, LF | 64'h1100, 1'b1, 3'd4, 64'd0, 3'b000, 4'd3, 4'd5},
        // R5 level-2 not valid, stops after two reads
        '{VA, 3'b001, 2'd0, 1'b0, L1G, 64'h0000_0200_0000_0100, LF | 64'h1101, 1'b1, 3'd4, 64'd0, 3'b000, 4'd2, 4'd5},
        // R6 level-1 without kernel read
        '{VA, 3'b001, 2'd0, 1'b0, 64'h0000_0100_0000_0001, L2G, LF | 64'h1101, 1'b1, 3'd0, 64'd0, 3'b000, 4'd1, 4'd6},
        // R8 zero need on a bare valid leaf succeeds
        '{VA, 3'b000, 2'd0, 1'b0, L1G, L2G, LF | 64'h0001, 1'b0, 3'd0, PA, 3'b000, 4'd3, 4'd8},
        // R1 physical bypass of an otherwise badly signed address
        '{64'hFFFF_0000_1234_5678, 3'b010, 2'd1, 1'b1, L1G, L2G, LF, 1'b0, 3'd0, 64'hFFFF_0000_1234_5678, 3'b111, 4'd0, 4'd1},
        // R2 bad sign extension
        '{64'h0000_0800_0000_0000, 3'b001, 2'd0, 1'b0, L1G, L2G, LF, 1'b1, 3'd0, 64'd0, 3'b000, 4'd0, 4'd2},
        // R3 superpage kernel, bit 40 moved to bit 43
        '{64'hFFFF_FD12_3456_789A, 3'b001, 2'd0, 1'b0, L1G, L2G, LF, 1'b0, 3'd0, 64'h0000_0812_3456_789A, 3'b111, 4'd0, 4'd3},
        // R3 superpage user
        '{64'hFFFF_FD12_3456_789A, 3'b001, 2'd1, 1'b0, L1G, L2G, LF, 1'b1, 3'd0, 64'd0, 3'b000, 4'd0, 4'd3},
        // R7 privilege index 2 selects bit 10
        '{VA, 3'b001, 2'd2, 1'b0, L1G, L2G, LF | 64'h0401, 1'b0, 3'd0, PA, 3'b101, 4'd3, 4'd7},
        // R8 exec outranks read when both are needed
        '{VA, 3'b101, 2'd0, 1'b0, L1G, L2G, LF | 64'h010B, 1'b1, 3'd3, 64'd0, 3'b000, 4'd3, 4'd8},
        // R6 level-2 without kernel read
        '{VA, 3'b001, 2'd0, 1'b0, L1G, 64'h0000_0200_0000_0001, LF | 64'h1101, 1'b1, 3'd0, 64'd0, 3'b000, 4'd2, 4'd6},
        // R3 R4 negative address outside the window is walked
        '{64'hFFFF_F806_0280_E123, 3'b001, 2'd0, 1'b0, L1G, L2G, LF | 64'h1101, 1'b0, 3'd0, PA, 3'b111, 4'd3, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] vaddr = '0;
    logic [2:0]  need = '0;
    logic [1:0]  priv = '0;
    logic        phys_mode = 1'b0;
    logic [63:0] ptbase = PTB;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic        fault;
    logic [2:0]  fault_code;
    logic [63:0] paddr;
    logic [2:0]  perm;

    int total = 0;
    int failed = 0;
    int reads = 0;
    int lat = 0;
    int wait_cnt = 0;
    int addr_moves = 0;
    logic        hold_flag = 1'b0;
    logic [63:0] hold_addr = '0;
    logic [63:0] cur_l1 = '0, cur_l2 = '0, cur_l3 = '0, cur_va = '0;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .need(need),
        .priv(priv), .phys_mode(phys_mode), .ptbase(ptbase),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .fault_code(fault_code), .paddr(paddr), .perm(perm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R4 table model: entries sit where the walk rules place them
    function automatic logic [63:0] lookup(input logic [63:0] a);
        logic [63:0] b2 = (cur_l1 >> 32) << 13;
        logic [63:0] b3 = (cur_l2 >> 32) << 13;
        if (a == PTB + ({54'd0, cur_va[42:33]} << 3)) return cur_l1;
        if (a == b2 + ({54'd0, cur_va[32:23]} << 3)) return cur_l2;
        if (a == b3 + ({54'd0, cur_va[22:13]} << 3)) return cur_l3;
        return 64'd0;
    endfunction

    // Responder, driven away from the active edge
    always @(negedge clk) begin
        if (hold_flag && mem_addr != hold_addr) addr_moves++;
        if (!rst_n) begin
            mem_valid = 1'b0;
            wait_cnt  = 0;
        end else if (mem_valid) begin
            mem_valid = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = lookup(mem_addr);
                reads++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
        hold_flag = mem_req && !mem_valid;
        hold_addr = mem_addr;
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            total++;
            failed++;
            $display("FAIL %s walk timeout: actual 0 expected 1", req);
        end
    endtask

    task automatic run_vec(input vec_t v);
        string req;
        req = $sformatf("R%0d", v.tag);
        cur_l1 = v.l1; cur_l2 = v.l2; cur_l3 = v.l3; cur_va = v.va;
        reads = 0;
        vaddr = v.va; need = v.need; priv = v.priv; phys_mode = v.phys;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(req);
        check(req, "fault", {63'd0, fault}, {63'd0, v.efault});
        check(req, "code", {61'd0, fault_code}, {61'd0, v.ecode});
        check(req, "paddr", paddr, v.epa);
        check(req, "perm", {61'd0, perm}, {61'd0, v.eperm});
        check(req, "reads", 64'(reads), {60'd0, v.ereads});
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        failed++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "reset done", {63'd0, done}, 64'd0);
        check("R10", "reset req", {63'd0, mem_req}, 64'd0);
        check("R10", "reset fault", {63'd0, fault}, 64'd0);
        check("R10", "reset paddr", paddr, 64'd0);
        check("R10", "reset perm", {61'd0, perm}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        lat = 0;
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9 same walks with a slow responder
        lat = 3;
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        check("R9", "address moved while pending", 64'(addr_moves), 64'd0);

        // R10 start while busy is ignored
        cur_l1 = L1G; cur_l2 = L2G; cur_l3 = LF | 64'h1101; cur_va = VA;
        reads = 0;
        vaddr = VA; need = 3'b001; priv = 2'd0; phys_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        vaddr = 64'h0000_0000_0000_5555; phys_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; phys_mode = 1'b0;
        wait_done("R10");
        check("R10", "busy start paddr", paddr, PA);
        check("R10", "busy start reads", 64'(reads), 64'd3);

        // R10 pulse width and result hold
        held = paddr;
        @(negedge clk);
        check("R10", "done one cycle", {63'd0, done}, 64'd0);
        repeat (3) @(negedge clk);
        check("R10", "result held", paddr, held);
        check("R10", "perm held", {61'd0, perm}, 64'd7);

        finish_up();
    end

endmodule